// File: doc/BRIEF.md
# SMBus Line-State Supervisor

This block sits beside the slave-side SMBus protocol engine and watches the raw clock and data lines. It cleans the two lines, measures how long they stay in particular states against a millisecond time base, and raises timing events. These events tell the engine when to give up on a transaction, when the bus has gone dead, and when the bus is quiet enough to run an offset calibration.

The engine reports where each message begins and ends, and whether the slave itself is currently holding the clock low. With that information the supervisor runs several checks:
- the length of each single clock-low phase;
- idle time with both lines high inside a message;
- the total clock stretching by slave and by master over one message;
- one shared both-low duration used for the bus-off state and for the calibration trigger.

All limits are parameters counted in millisecond ticks. Pulse outputs last one clock cycle. The bus-off and availability outputs are levels.

Top module: `smbus_line_supervisor`

## Requirements
- R1: Each line passes through a two-flop synchronizer and then a filter that changes its output only after 3 consecutive equal samples. A pulse of 2 or fewer cycles on a line has no effect on any duration measurement.
- R2: When the filtered clock has stayed low for TLOW_TICKS ticks (default 26, which is more than 25 ms), timeout_o pulses once for that low phase.
- R3: Inside a message, both lines high for IDLE_TICKS ticks (default 51) pulses abort_o. When idle_chk_off_i is 1, this check is disabled.
- R4: Inside a message, clock-low ticks counted while slv_hold_i is 1 accumulate from start to stop. Reaching SEXT_TICKS (default 26) pulses abort_o.
- R5: Inside a message, clock-low ticks counted while slv_hold_i is 0 accumulate the same way. Reaching MEXT_TICKS (default 11) pulses abort_o.
- R6: Both lines low for BUSOFF_TICKS consecutive ticks (default 2000) sets bus_off_o and clears bus_avail_o.
- R7: bus_off_o clears as soon as either filtered line is high. bus_avail_o returns to 1 on the next ms tick after that.
- R8: Both lines low for CAL_TICKS consecutive ticks (default 5000) gives a single cal_req_o pulse, only once per low episode.
- R9: Each duration counter clears when its condition breaks. For example, two clock-low phases of TLOW_TICKS-1 ticks each, separated by a high phase, give no timeout.
- R10: After reset, bus_avail_o is 1 and timeout_o, abort_o, bus_off_o and cal_req_o are 0.
- R11: A message runs from start_det_i until stop_det_i or an abort. Outside a message, a timeout still pulses timeout_o but never abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SMBus clock line level |
| sda_i | input | 1 | Raw SMBus data line level |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| start_det_i | input | 1 | Start condition seen by the protocol engine |
| stop_det_i | input | 1 | Stop condition seen by the protocol engine |
| slv_hold_i | input | 1 | Slave is currently stretching the clock |
| idle_chk_off_i | input | 1 | 1 disables the in-message idle check |
| timeout_o | output | 1 | Clock-low timeout pulse |
| abort_o | output | 1 | Transaction-abort pulse |
| bus_off_o | output | 1 | Bus-off state |
| bus_avail_o | output | 1 | Bus usable |
| cal_req_o | output | 1 | Calibration request pulse |

## Verification
The hardest state to reach is the calibration request. Both lines must stay low for thousands of ticks, which is long enough to pass through the timeout and bus-off events on the way. The bench owns the tick input and steps it directly, so the 5000-tick episode costs only about 20k cycles. It checks the bus-off boundary, the calibration boundary and the single-pulse property along the way. Stretch accumulation across several low phases is driven by splitting the clock-low time into phases that are each shorter than the timeout. This way the cumulative limit fires while the per-phase limit does not.

// File: rtl/smbls_pkg.sv
package smbls_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  function automatic logic both_low(bus_lines_t l);
    return ~l.scl & ~l.sda;
  endfunction

  function automatic logic both_high(bus_lines_t l);
    return l.scl & l.sda;
  endfunction
endpackage

// File: rtl/smbls_line_filter.sv
module smbls_line_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  logic s1, s2;
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      hist   <= '1;
      filt_o <= 1'b1;
    end else begin
      s1   <= raw_i;
      s2   <= s1;
      hist <= {hist[DEPTH-2:0], s2};
      if (&hist)       filt_o <= 1'b1;
      else if (~|hist) filt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smbls_dur_counter.sv
module smbls_dur_counter #(
  parameter int LIMIT = 26,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic step;
  assign step  = tick_i & en_i & ~clr_i & (cnt_o != W'(LIMIT));
  assign hit_o = step & (cnt_o == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (step)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/smbus_line_supervisor.sv
module smbus_line_supervisor #(
  parameter int TLOW_TICKS   = 26,
  parameter int IDLE_TICKS   = 51,
  parameter int SEXT_TICKS   = 26,
  parameter int MEXT_TICKS   = 11,
  parameter int BUSOFF_TICKS = 2000,
  parameter int CAL_TICKS    = 5000,
  parameter int FILT_DEPTH   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ms_tick_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic slv_hold_i,
  input  logic idle_chk_off_i,
  output logic timeout_o,
  output logic abort_o,
  output logic bus_off_o,
  output logic bus_avail_o,
  output logic cal_req_o
);
  import smbls_pkg::*;

  localparam int BLW = $clog2(CAL_TICKS + 1);
  localparam int NLINES = 2;

  bus_lines_t lines;
  logic [NLINES-1:0] raw_v, filt_v;
  assign raw_v = {scl_i, sda_i};

  // R1: one synchronizer and glitch filter per line
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smbls_line_filter #(.DEPTH(FILT_DEPTH)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_v[g]), .filt_o(filt_v[g])
    );
  end
  assign lines.scl = filt_v[1];
  assign lines.sda = filt_v[0];

  logic in_msg;
  logic lo_both, hi_both;
  assign lo_both = both_low(lines);
  assign hi_both = both_high(lines);

  // R2/R9: single clock-low phase
  logic low_hit;
  logic [$clog2(TLOW_TICKS+1)-1:0] low_cnt;
  smbls_dur_counter #(.LIMIT(TLOW_TICKS)) u_low (
    .clk(clk), .rst_n(rst_n), .clr_i(lines.scl), .en_i(1'b1),
    .tick_i(ms_tick_i), .cnt_o(low_cnt), .hit_o(low_hit)
  );

  // R3: idle inside a message
  logic idle_hit;
  logic [$clog2(IDLE_TICKS+1)-1:0] idle_cnt;
  smbls_dur_counter #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .clr_i(~hi_both | ~in_msg | idle_chk_off_i), .en_i(1'b1),
    .tick_i(ms_tick_i), .cnt_o(idle_cnt), .hit_o(idle_hit)
  );

  // R4/R5: cumulative stretch, cleared at each start
  logic sext_hit, mext_hit;
  logic [$clog2(SEXT_TICKS+1)-1:0] sext_cnt;
  logic [$clog2(MEXT_TICKS+1)-1:0] mext_cnt;
  smbls_dur_counter #(.LIMIT(SEXT_TICKS)) u_sext (
    .clk(clk), .rst_n(rst_n), .clr_i(start_det_i),
    .en_i(in_msg & ~lines.scl & slv_hold_i),
    .tick_i(ms_tick_i), .cnt_o(sext_cnt), .hit_o(sext_hit)
  );
  smbls_dur_counter #(.LIMIT(MEXT_TICKS)) u_mext (
    .clk(clk), .rst_n(rst_n), .clr_i(start_det_i),
    .en_i(in_msg & ~lines.scl & ~slv_hold_i),
    .tick_i(ms_tick_i), .cnt_o(mext_cnt), .hit_o(mext_hit)
  );

  // R6/R8: shared both-low duration
  logic cal_hit;
  logic [BLW-1:0] bl_cnt;
  smbls_dur_counter #(.LIMIT(CAL_TICKS)) u_both (
    .clk(clk), .rst_n(rst_n), .clr_i(~lo_both), .en_i(1'b1),
    .tick_i(ms_tick_i), .cnt_o(bl_cnt), .hit_o(cal_hit)
  );

  logic busoff_hit;
  assign busoff_hit = ms_tick_i & lo_both & (bl_cnt == BLW'(BUSOFF_TICKS - 1));

  logic abort_now;
  assign abort_now = in_msg & (low_hit | idle_hit | sext_hit | mext_hit);

  logic recov;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg    <= 1'b0;
      timeout_o <= 1'b0;
      abort_o   <= 1'b0;
      cal_req_o <= 1'b0;
      bus_off_o <= 1'b0;
      recov     <= 1'b0;
    end else begin
      timeout_o <= low_hit;
      abort_o   <= abort_now;
      cal_req_o <= cal_hit;
      if (start_det_i)                 in_msg <= 1'b1;
      else if (stop_det_i | abort_now) in_msg <= 1'b0;
      // R6/R7: bus-off entry, exit and recovery delay
      if (busoff_hit) begin
        bus_off_o <= 1'b1;
      end else if (bus_off_o & ~lo_both) begin
        bus_off_o <= 1'b0;
        recov     <= 1'b1;
      end else if (recov & ms_tick_i) begin
        recov     <= 1'b0;
      end
    end
  end

  assign bus_avail_o = ~(bus_off_o | recov);
endmodule

// File: rtl/smbls_checker.sv
module smbls_checker (
  input logic clk,
  input logic rst_n,
  input logic ms_tick_i,
  input logic timeout_o,
  input logic abort_o,
  input logic bus_off_o,
  input logic bus_avail_o,
  input logic cal_req_o
);
  // R6
  a_r6_off_not_avail: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_o |-> !bus_avail_o);
  // R7
  a_r7_avail_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_avail_o) |-> $past(ms_tick_i));
  // R8
  a_r8_cal_in_busoff: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |-> bus_off_o);
  // R8
  a_r8_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |=> !cal_req_o);
  // R2
  a_r2_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  // R11
  a_r11_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
endmodule

bind smbus_line_supervisor smbls_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i),
  .timeout_o(timeout_o), .abort_o(abort_o), .bus_off_o(bus_off_o),
  .bus_avail_o(bus_avail_o), .cal_req_o(cal_req_o)
);

// File: tb/tb_smbus_line_supervisor.sv
`timescale 1ns/1ps
module tb_smbus_line_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, tick = 1'b0;
  logic start_d = 1'b0, stop_d = 1'b0, shold = 1'b0, idle_off = 1'b0;
  logic timeout_o, abort_o, bus_off_o, bus_avail_o, cal_req_o;

  int n_to = 0, n_ab = 0, n_cal = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smbus_line_supervisor dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .ms_tick_i(tick),
    .start_det_i(start_d), .stop_det_i(stop_d), .slv_hold_i(shold),
    .idle_chk_off_i(idle_off), .timeout_o(timeout_o), .abort_o(abort_o),
    .bus_off_o(bus_off_o), .bus_avail_o(bus_avail_o), .cal_req_o(cal_req_o)
  );

  always @(negedge clk) begin
    if (timeout_o) n_to++;
    if (abort_o)   n_ab++;
    if (cal_req_o) n_cal++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic lines(logic c, logic d);
    @(negedge clk);
    scl = c; sda = d;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_d = 1'b1;
    @(negedge clk) start_d = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_d = 1'b1;
    @(negedge clk) stop_d = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 avail", int'(bus_avail_o), 1);
    check("R10 busoff", int'(bus_off_o), 0);
    check("R10 pulses", int'(timeout_o | abort_o | cal_req_o), 0);
  endtask

  task automatic t_timeout_outside();
    int to0 = n_to, ab0 = n_ab;
    lines(1'b0, 1'b1);
    ticks(25);
    check("R2 before limit", n_to - to0, 0);
    ticks(1);
    check("R2 at limit", n_to - to0, 1);
    ticks(10);
    check("R2 once per phase", n_to - to0, 1);
    check("R11 no abort outside msg", n_ab - ab0, 0);
    lines(1'b1, 1'b1);
  endtask

  task automatic t_counter_clear();
    int to0 = n_to;
    lines(1'b0, 1'b1); ticks(25);
    lines(1'b1, 1'b1);
    lines(1'b0, 1'b1); ticks(25);
    lines(1'b1, 1'b1);
    check("R9 split low phases", n_to - to0, 0);
  endtask

  task automatic t_idle();
    int ab0 = n_ab;
    pulse_start();
    ticks(50);
    check("R3 before idle limit", n_ab - ab0, 0);
    ticks(1);
    check("R3 idle abort", n_ab - ab0, 1);
    ab0 = n_ab;
    idle_off = 1'b1;
    pulse_start();
    ticks(60);
    check("R3 idle check disabled", n_ab - ab0, 0);
    pulse_stop();
    idle_off = 1'b0;
  endtask

  task automatic t_glitch();
    int ab0 = n_ab;
    pulse_start();
    ticks(30);
    @(negedge clk) scl = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (8) @(negedge clk);
    ticks(21);
    check("R1 glitch ignored", n_ab - ab0, 1);
  endtask

  task automatic t_slave_stretch();
    int ab0 = n_ab;
    shold = 1'b1;
    lines(1'b1, 1'b0);
    pulse_start();
    lines(1'b0, 1'b0); ticks(13);
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0); ticks(12);
    check("R4 below slave limit", n_ab - ab0, 0);
    ticks(1);
    check("R4 slave stretch abort", n_ab - ab0, 1);
    lines(1'b1, 1'b0);
    shold = 1'b0;
  endtask

  task automatic t_master_stretch();
    int ab0 = n_ab;
    lines(1'b1, 1'b0);
    pulse_start();
    lines(1'b0, 1'b0); ticks(6);
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0); ticks(4);
    check("R5 below master limit", n_ab - ab0, 0);
    ticks(1);
    check("R5 master stretch abort", n_ab - ab0, 1);
    lines(1'b1, 1'b0);
    pulse_stop();
    lines(1'b1, 1'b1);
  endtask

  task automatic t_busoff_cal();
    int c0 = n_cal;
    lines(1'b0, 1'b0);
    ticks(1999);
    check("R6 before busoff", int'(bus_off_o), 0);
    ticks(1);
    check("R6 busoff set", int'(bus_off_o), 1);
    check("R6 avail cleared", int'(bus_avail_o), 0);
    ticks(2999);
    check("R8 before cal", n_cal - c0, 0);
    ticks(1);
    check("R8 cal pulse", n_cal - c0, 1);
    ticks(100);
    check("R8 cal once per episode", n_cal - c0, 1);
    lines(1'b0, 1'b1);
    check("R7 busoff cleared", int'(bus_off_o), 0);
    check("R7 avail waits for tick", int'(bus_avail_o), 0);
    ticks(1);
    check("R7 avail after tick", int'(bus_avail_o), 1);
    lines(1'b1, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_timeout_outside();
    t_counter_clear();
    t_idle();
    t_glitch();
    t_slave_stretch();
    t_master_stretch();
    t_busoff_cal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule